// File: doc/BRIEF.md
# Sample Output Demultiplexer

This block sits behind an 8-bit converter core. It accepts one sample on every rising edge of the sample clock and steers the samples onto two 8-bit output ports, called primary and auxiliary. There are three modes. In pass-through mode every sample goes to the primary port. In split mode consecutive samples are paired across the two ports, so each port updates at half the sample rate. In decimating mode every other sample is dropped and the remaining samples are paired, so each port updates at a quarter of the sample rate.

A 2-bit phase counter tags each accepted sample. A synchronous phase-reset input clears this counter so that several devices can be phase-aligned. The phase-reset input is echoed on an output so it can be passed on to a neighbouring device. A ready strobe is registered on the same edge as both data ports. In the split and decimating modes its falling edge falls in the middle of each output word's valid window. An auxiliary-enable input forces the auxiliary port to zero when it is low.

All latencies are counted in whole sample-clock edges. The primary port trails its sample by 8 edges. The auxiliary port trails its sample by 9 edges in split mode and by 10 edges in decimating mode. With these latencies both words of a pair come out on the same edge.

Top module: `adc_out_demux`

## Requirements
- R1: With demux_en_i = 0 (pass-through), pri_o shows, after edge n, the sample accepted at edge n-8, and aux_o stays 0.
- R2: With demux_en_i = 1 and div4_i = 0 (split), the output updates at edge n whenever the sample accepted at edge n-8 had odd phase. On an update, pri_o takes that sample and aux_o takes the sample accepted at edge n-9. Between updates both ports hold.
- R3: With demux_en_i = 1 and div4_i = 1 (decimating), the output updates at edge n whenever the sample accepted at edge n-8 had phase 2. On an update, pri_o takes that sample and aux_o takes the sample accepted at edge n-10. Samples with phase 1 or 3 are never output.
- R4: The phase of the first sample after asynchronous reset is 0, and each following sample's phase is one higher, modulo 4. A sample accepted on the edge after an edge that saw sync_rst_i = 1 has phase 0.
- R5: After each edge, sync_rst_o equals the value sync_rst_i had at that edge.
- R6: An edge that sees aux_en_i = 0 leaves aux_o at 0. Once the enable returns, aux_o stays 0 until the next update.
- R7: In pass-through mode, ready_o inverts on every edge, starting from 0 after reset. In split mode, ready_o after edge n is the low bit of the phase of the sample accepted at edge n-8. In decimating mode it is the high bit of that phase. So in the two demux modes ready_o rises on the same edge that updates the data.
- R8: While rst_ni is low, pri_o, aux_o, ready_o and sync_rst_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Sample word from the converter core |
| demux_en_i | input | 1 | 1 selects split or decimating mode; 0 selects pass-through |
| div4_i | input | 1 | With demux_en_i = 1: 1 selects decimating mode, 0 selects split mode |
| aux_en_i | input | 1 | Auxiliary port enable; 0 forces aux_o to zero |
| sync_rst_i | input | 1 | Synchronous phase reset |
| pri_o | output | 8 | Primary output word |
| aux_o | output | 8 | Auxiliary output word |
| ready_o | output | 1 | Data-ready strobe, registered with the data |
| sync_rst_o | output | 1 | Phase reset echoed to downstream devices |

## Verification
The properties assume that every control input is a clean level, synchronous to clk_i and settled between rising edges. This applies in particular to sync_rst_i, which is sampled as a single-edge level with no synchronizer. The stimulus drives all inputs on falling edges. It changes the mode pins only while rst_ni is held low, so the delay line is never filled with samples taken under a different mode. Phase-reset pulses of one, two and three cycles are placed at several phases. The auxiliary enable is dropped partway through a split-mode run, so the hold-at-zero and recovery behaviour is seen against a moving phase.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

  typedef enum logic [1:0] {
    MODE_DIV1 = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2
  } mode_e;

  localparam int unsigned PH_W = 2;

  function automatic mode_e decode_mode(input logic demux_en, input logic div4);
    if (!demux_en) return MODE_DIV1;
    if (div4)      return MODE_DIV4;
    return MODE_DIV2;
  endfunction

endpackage

// File: rtl/adc_demux_phase.sv
module adc_demux_phase #(
  parameter int unsigned PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_rst_i,
  output logic [PH_W-1:0] ph_o,
  output logic            sync_rst_o
);

  logic [PH_W-1:0] ph_q;
  logic            echo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      echo_q <= 1'b0;
    end else begin
      echo_q <= sync_rst_i;
      ph_q   <= sync_rst_i ? '0 : ph_q + {{(PH_W-1){1'b0}}, 1'b1};
    end
  end

  assign ph_o       = ph_q;
  assign sync_rst_o = echo_q;

  p_phase_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> ph_q == '0);

  p_phase_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_rst_i |=> ph_q == PH_W'($past(ph_q) + 1));

  p_sync_echo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sync_rst_o == $past(sync_rst_i));

endmodule

// File: rtl/adc_demux_delay.sv
module adc_demux_delay #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PH_W   = 2,
  parameter int unsigned DEPTH  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PH_W-1:0]   ph_i,
  output logic [DATA_W-1:0] tap_pri_o,
  output logic [DATA_W-1:0] tap_aux2_o,
  output logic [DATA_W-1:0] tap_aux4_o,
  output logic [PH_W-1:0]   ph_pri_o
);

  localparam int unsigned PH_DEPTH = DEPTH - 2;

  logic [DEPTH-1:0][DATA_W-1:0]  dat_q;
  logic [PH_DEPTH-1:0][PH_W-1:0] ph_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dat_q[g] <= '0;
      else if (g == 0) dat_q[g] <= data_i;
      else             dat_q[g] <= dat_q[(g == 0) ? 0 : g-1];
    end
  end

  // phase tag only needs to reach the primary tap
  for (genvar g = 0; g < PH_DEPTH; g++) begin : g_ph
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ph_q[g] <= '0;
      else if (g == 0) ph_q[g] <= ph_i;
      else             ph_q[g] <= ph_q[(g == 0) ? 0 : g-1];
    end
  end

  assign tap_pri_o  = dat_q[DEPTH-3];
  assign tap_aux2_o = dat_q[DEPTH-2];
  assign tap_aux4_o = dat_q[DEPTH-1];
  assign ph_pri_o   = ph_q[PH_DEPTH-1];

endmodule

// File: rtl/adc_demux_out.sv
module adc_demux_out
  import adc_demux_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              aux_en_i,
  input  logic [PH_W-1:0]   ph_i,
  input  logic [DATA_W-1:0] pri_src_i,
  input  logic [DATA_W-1:0] aux2_src_i,
  input  logic [DATA_W-1:0] aux4_src_i,
  output logic [DATA_W-1:0] pri_o,
  output logic [DATA_W-1:0] aux_o,
  output logic              ready_o
);

  logic              upd;
  logic              rdy_d;
  logic [DATA_W-1:0] aux_src;
  logic [DATA_W-1:0] pri_q, aux_q;
  logic              rdy_q;

  always_comb begin
    unique case (mode_i)
      MODE_DIV2: begin
        upd     = ph_i[0];
        rdy_d   = ph_i[0];
        aux_src = aux2_src_i;
      end
      MODE_DIV4: begin
        upd     = (ph_i == PH_W'(2));
        rdy_d   = ph_i[PH_W-1];
        aux_src = aux4_src_i;
      end
      default: begin
        upd     = 1'b1;
        rdy_d   = ~rdy_q;
        aux_src = '0;
      end
    endcase
  end

  // data and strobe share one register edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= '0;
      aux_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      if (upd) pri_q <= pri_src_i;
      if (!aux_en_i || mode_i == MODE_DIV1) aux_q <= '0;
      else if (upd)                          aux_q <= aux_src;
    end
  end

  assign pri_o   = pri_q;
  assign aux_o   = aux_q;
  assign ready_o = rdy_q;

  p_aux_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_en_i |=> aux_o == '0);

  p_div1_aux_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_DIV1 |=> aux_o == '0);

  p_div1_ready_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_DIV1 |=> ready_o != $past(ready_o));

  p_update_marked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) != MODE_DIV1) && !$stable(pri_o) |-> ready_o);

endmodule

// File: rtl/adc_out_demux.sv
module adc_out_demux
  import adc_demux_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PRI_LAT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              demux_en_i,
  input  logic              div4_i,
  input  logic              aux_en_i,
  input  logic              sync_rst_i,
  output logic [DATA_W-1:0] pri_o,
  output logic [DATA_W-1:0] aux_o,
  output logic              ready_o,
  output logic              sync_rst_o
);

  // output register adds one edge; aux taps sit one and two past primary
  localparam int unsigned PRI_TAP = PRI_LAT - 1;
  localparam int unsigned DEPTH   = PRI_TAP + 3;

  mode_e             mode;
  logic [PH_W-1:0]   ph;
  logic [PH_W-1:0]   ph_pri;
  logic [DATA_W-1:0] tap_pri, tap_aux2, tap_aux4;

  assign mode = decode_mode(demux_en_i, div4_i);

  adc_demux_phase #(.PH_W(PH_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_rst_i (sync_rst_i),
    .ph_o       (ph),
    .sync_rst_o (sync_rst_o)
  );

  adc_demux_delay #(.DATA_W(DATA_W), .PH_W(PH_W), .DEPTH(DEPTH)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (sample_i),
    .ph_i       (ph),
    .tap_pri_o  (tap_pri),
    .tap_aux2_o (tap_aux2),
    .tap_aux4_o (tap_aux4),
    .ph_pri_o   (ph_pri)
  );

  adc_demux_out #(.DATA_W(DATA_W), .PH_W(PH_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .aux_en_i   (aux_en_i),
    .ph_i       (ph_pri),
    .pri_src_i  (tap_pri),
    .aux2_src_i (tap_aux2),
    .aux4_src_i (tap_aux4),
    .pri_o      (pri_o),
    .aux_o      (aux_o),
    .ready_o    (ready_o)
  );

endmodule

// File: tb/adc_out_demux_bench.sv
module adc_out_demux_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sample_i = '0;
  logic       demux_en_i = 1'b0;
  logic       div4_i = 1'b0;
  logic       aux_en_i = 1'b1;
  logic       sync_rst_i = 1'b0;
  logic [7:0] pri_o, aux_o;
  logic       ready_o, sync_rst_o;

  adc_out_demux u_adc_out_demux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .demux_en_i (demux_en_i),
    .div4_i     (div4_i),
    .aux_en_i   (aux_en_i),
    .sync_rst_i (sync_rst_i),
    .pri_o      (pri_o),
    .aux_o      (aux_o),
    .ready_o    (ready_o),
    .sync_rst_o (sync_rst_o)
  );

  always #10 clk_i = ~clk_i;

  int         checks = 0;
  int         fails  = 0;
  int         n      = 0;
  int         md     = 0;
  logic [7:0] hist_s  [0:1023];
  logic       hist_sy [0:1023];
  int         ph_m    [0:1023];
  logic [7:0] exp_pri, exp_aux;

  function automatic logic [7:0] get_s(input int k);
    return (k < 1) ? 8'd0 : hist_s[k];
  endfunction

  function automatic int get_p(input int k);
    return (k < 1) ? 0 : ph_m[k];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, n, act, exp);
    end
  endtask

  // R8: all outputs zero while reset is held
  task automatic do_reset(input int mode);
    @(negedge clk_i);
    rst_ni     = 1'b0;
    md         = mode;
    demux_en_i = (mode != 0);
    div4_i     = (mode == 2);
    sync_rst_i = 1'b0;
    aux_en_i   = 1'b1;
    @(negedge clk_i);
    chk("R8", pri_o, 8'd0);
    chk("R8", aux_o, 8'd0);
    chk("R8", {7'd0, ready_o}, 8'd0);
    chk("R8", {7'd0, sync_rst_o}, 8'd0);
    rst_ni  = 1'b1;
    n       = 0;
    exp_pri = '0;
    exp_aux = '0;
  endtask

  task automatic run_cycle(input logic [7:0] s, input logic sy, input logic ae,
                           input string tag_d, input string tag_a);
    int p;
    logic upd;
    logic rdy;
    sample_i   = s;
    sync_rst_i = sy;
    aux_en_i   = ae;
    hist_s[n+1]  = s;
    hist_sy[n+1] = sy;
    @(posedge clk_i);
    n++;
    ph_m[n] = (n == 1) ? 0 : (hist_sy[n-1] ? 0 : (ph_m[n-1] + 1) % 4);
    p = get_p(n - 8);
    if (md == 0) begin        // R1 pass-through
      exp_pri = get_s(n - 8);
      exp_aux = 8'd0;
      rdy     = n[0];
    end else if (md == 1) begin  // R2 split
      upd = (p % 2 == 1);
      if (upd) exp_pri = get_s(n - 8);
      if (!ae) exp_aux = 8'd0;
      else if (upd) exp_aux = get_s(n - 9);
      rdy = (p % 2 == 1);
    end else begin            // R3 decimating
      upd = (p == 2);
      if (upd) exp_pri = get_s(n - 8);
      if (!ae) exp_aux = 8'd0;
      else if (upd) exp_aux = get_s(n - 10);
      rdy = (p >= 2);
    end
    @(negedge clk_i);
    chk(tag_d, pri_o, exp_pri);
    chk(tag_a, aux_o, exp_aux);
    chk("R7", {7'd0, ready_o}, {7'd0, rdy});
    chk("R5", {7'd0, sync_rst_o}, {7'd0, sy});
  endtask

  task automatic run_scn(input int mode, input int len, input int mul, input int add,
                         input int s1, input int l1, input int s2, input int l2,
                         input int off_lo, input int off_hi,
                         input string tag_d, input string tag_a);
    do_reset(mode);
    for (int i = 1; i <= len; i++) begin
      logic sy;
      logic ae;
      sy = (i >= s1 && i < s1 + l1) || (i >= s2 && i < s2 + l2);
      ae = !(i >= off_lo && i <= off_hi);
      run_cycle(8'((i * mul + add) % 256), sy, ae, tag_d, tag_a);
    end
  endtask

  initial begin
    // R1: every 8-bit value passes through (97 is odd, so i*97 covers all codes)
    run_scn(0, 270, 97, 5, 0, 0, 0, 0, 0, -1, "R1", "R1");
    // R2: split mode with single and double phase-reset pulses
    run_scn(1, 80, 53, 17, 23, 1, 40, 2, 0, -1, "R2", "R2");
    // R3: decimating mode with a three-cycle and a single pulse
    run_scn(2, 80, 29, 3, 30, 3, 57, 1, 0, -1, "R3", "R3");
    // R4 / R6: phase realignment plus auxiliary power-down window
    run_scn(1, 70, 71, 9, 15, 1, 44, 1, 20, 35, "R4", "R6");
    // R6 in decimating mode
    run_scn(2, 60, 13, 200, 19, 1, 0, 0, 25, 41, "R3", "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(64'd4_000_000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule